// File: doc/BRIEF.md
# Exception entry sequencer

This block sits beside a simple in-order pipeline and performs the architectural side of taking an exception. The pipeline presents at most one fault at a time on a valid/ready request channel. A request carries the fault kind, a store flag, the faulting PC, the faulting virtual address, an address-space tag, a virtual page number and a coprocessor index. When the block accepts a request it updates every affected control register at one clock edge. In that same cycle it raises a one-cycle redirect pulse that carries the handler address.

The handler address is a vector base plus an offset. The base is either a fixed boot address or a programmable base register, chosen by a boot-select status bit. The offset depends on the fault kind, the vector-spread bit in the cause state and the in-handler status bit. Address faults and translation faults also capture the bad address. Translation faults additionally load the translation-high fields and the context page field in the same cycle.

The request channel follows valid/ready rules. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The requester must hold the request stable until it is taken. `req_ready` is low during the redirect cycle and during any cycle in which the control-write strobe is high. A plain control-write strobe loads the boot-select bit, the in-handler bit, the vector-spread bit and the base register.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, `redirect_valid`, the cause code, the coprocessor field, the saved PC, the bad address, all translation fields, `stat_exl`, `cause_spread` and `vec_base` are zero. `stat_boot` is 1 and `req_ready` is 1.
- R2: A request taken at one edge makes `redirect_valid` high for exactly the following cycle, with `redirect_pc`. `req_ready` is low in that cycle and whenever `ctl_wr` is high. No request is lost or duplicated.
- R3: The vector base is 0xBFC00200 when `stat_boot` is 1 and `vec_base` when it is 0. Kinds other than interrupt and translation refill use offset 0x180.
- R4: An interrupt (kind 0) uses offset 0x200 when `cause_spread` is 1 and 0x180 when it is 0.
- R5: A translation refill (kind 2) uses offset 0x000 when `stat_exl` is 0 at acceptance and 0x180 when it is 1.
- R6: The 4-bit `req_kind` maps to a 5-bit cause code as follows. 0 interrupt→0, 1 translation-modified→1, 2 refill, 3 translation-invalid, 4 address error, 5 instruction-bus error→6, 6 data-bus error→7, 7 syscall→8, 8 breakpoint→9, 9 reserved instruction→10, 10 coprocessor unusable→11, 11 overflow→12, 12 trap→13, 13 watch→23, 14 machine check→24, 15 thread→25.
- R7: Kinds 2 and 3 report code 3 when `req_store` is 1 and 2 otherwise. Kind 4 reports 5 for a store and 4 for a load. Kind 1 reports 1 regardless of `req_store`.
- R8: Kinds 1 to 4 load `bad_vaddr` with `req_vaddr`. All other kinds leave it unchanged.
- R9: Kinds 1 to 3 load `tr_asid` with `req_asid`, `tr_vpn2` and `ctx_badvpn2` with `req_vpn` shifted right by 2, and `tr_vpn2x` with `req_vpn[1:0]`. All other kinds leave these fields unchanged.
- R10: Kind 10 loads `cause_ce` with `req_cop`. All other kinds leave it unchanged.
- R11: If `stat_exl` is 0 at acceptance, `epc` takes `req_pc` and `stat_exl` becomes 1. If it is already 1, `epc` is unchanged.
- R12: When `ctl_wr` is high at an edge, `stat_boot`, `stat_exl`, `cause_spread` and `vec_base` take `ctl_boot`, `ctl_exl`, `ctl_spread` and `ctl_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fault request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_kind | input | 4 | Fault kind (see R6) |
| req_store | input | 1 | Faulting access was a store |
| req_pc | input | 32 | PC of the faulting instruction |
| req_vaddr | input | 32 | Faulting virtual address |
| req_asid | input | 8 | Address-space tag of the access |
| req_vpn | input | 21 | Virtual page number, low two bits are the extension |
| req_cop | input | 2 | Coprocessor index for kind 10 |
| ctl_wr | input | 1 | Control-write strobe |
| ctl_boot | input | 1 | Boot-select value to write |
| ctl_exl | input | 1 | In-handler value to write |
| ctl_spread | input | 1 | Vector-spread value to write |
| ctl_base | input | 32 | Vector base value to write |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | 32 | Handler address |
| stat_boot | output | 1 | Boot-select status bit |
| stat_exl | output | 1 | In-handler status bit |
| cause_spread | output | 1 | Vector-spread bit |
| vec_base | output | 32 | Vector base register |
| cause_code | output | 5 | Exception code |
| cause_ce | output | 2 | Coprocessor field |
| epc | output | 32 | Saved PC |
| bad_vaddr | output | 32 | Bad virtual address |
| tr_asid | output | 8 | Translation-high address-space tag |
| tr_vpn2 | output | 19 | Translation-high page-pair number |
| tr_vpn2x | output | 2 | Translation-high extension bits |
| ctx_badvpn2 | output | 19 | Context page-pair field |

## Verification
The embedded properties check the handshake on every cycle. The redirect is a single pulse, a taken request is always followed by a redirect with `req_ready` low, and `stat_exl` is set whenever a redirect is out. They also check that the saved PC stays put on a nested fault, that the coprocessor field moves only on kind 10, that the modified kind always reports code 1, and that the context and translation-high page fields agree after a translation fault. Only the bench scenarios can show that the handler address is correct across every combination of kind, boot select, spread and in-handler state. The same holds for each cause code and store variant, and for every "unchanged" register surviving the kinds that must not touch it. The bench sweeps all 16 kinds over all eight status settings and also sends requests back to back.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [3:0] {
    K_INTR      = 4'd0,
    K_TLB_MOD   = 4'd1,
    K_TLB_REFIL = 4'd2,
    K_TLB_INVAL = 4'd3,
    K_ADDR_ERR  = 4'd4,
    K_IBUS_ERR  = 4'd5,
    K_DBUS_ERR  = 4'd6,
    K_SYSCALL   = 4'd7,
    K_BREAK     = 4'd8,
    K_RSVD_INSN = 4'd9,
    K_COP_UNUSE = 4'd10,
    K_OVERFLOW  = 4'd11,
    K_TRAP      = 4'd12,
    K_WATCH     = 4'd13,
    K_MCHECK    = 4'd14,
    K_THREAD    = 4'd15
  } fault_kind_e;

  localparam int CODE_W = 5;

  // classification produced by the code map, consumed by the top
  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              is_xlat;  // translation-class fault
    logic              is_addr;  // captures the bad address
    logic              is_cop;   // writes the coprocessor field
  } fault_class_t;

endpackage

// File: rtl/exc_code_map.sv
module exc_code_map
  import exc_entry_pkg::*;
(
  input  fault_kind_e  kind,
  input  logic         store,
  output fault_class_t cls
);

  always_comb begin
    cls = '0;
    unique case (kind)
      K_INTR:      cls.code = 5'd0;
      K_TLB_MOD:   begin cls.code = 5'd1; cls.is_xlat = 1'b1; cls.is_addr = 1'b1; end
      K_TLB_REFIL,
      K_TLB_INVAL: begin
        cls.code    = store ? 5'd3 : 5'd2;
        cls.is_xlat = 1'b1;
        cls.is_addr = 1'b1;
      end
      K_ADDR_ERR:  begin cls.code = store ? 5'd5 : 5'd4; cls.is_addr = 1'b1; end
      K_IBUS_ERR:  cls.code = 5'd6;
      K_DBUS_ERR:  cls.code = 5'd7;
      K_SYSCALL:   cls.code = 5'd8;
      K_BREAK:     cls.code = 5'd9;
      K_RSVD_INSN: cls.code = 5'd10;
      K_COP_UNUSE: begin cls.code = 5'd11; cls.is_cop = 1'b1; end
      K_OVERFLOW:  cls.code = 5'd12;
      K_TRAP:      cls.code = 5'd13;
      K_WATCH:     cls.code = 5'd23;
      K_MCHECK:    cls.code = 5'd24;
      K_THREAD:    cls.code = 5'd25;
      default:     cls = '0;
    endcase
  end

  // R7: a translation fault is always an address-capturing fault
  always_comb begin
    if (cls.is_xlat) a_r7_xlat_is_addr: assert (cls.is_addr);
  end

endmodule

// File: rtl/exc_vec_calc.sv
module exc_vec_calc
  import exc_entry_pkg::*;
#(
  parameter int          AW         = 32,
  parameter logic [31:0] BOOT_VEC   = 32'hBFC0_0200,
  parameter int          OFF_GEN    = 'h180,
  parameter int          OFF_SPREAD = 'h200,
  parameter int          OFF_REFILL = 'h000
) (
  input  fault_kind_e   kind,
  input  logic          boot,
  input  logic          exl,
  input  logic          spread,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] pc
);

  localparam logic [AW-1:0] BOOT_A = AW'(BOOT_VEC);
  localparam logic [AW-1:0] GEN_A  = AW'(OFF_GEN);
  localparam logic [AW-1:0] SPR_A  = AW'(OFF_SPREAD);
  localparam logic [AW-1:0] REF_A  = AW'(OFF_REFILL);

  logic [AW-1:0] sel_base, sel_off;

  always_comb begin
    sel_base = boot ? BOOT_A : base;
    unique case (kind)
      K_INTR:      sel_off = spread ? SPR_A : GEN_A;
      K_TLB_REFIL: sel_off = exl ? GEN_A : REF_A;
      default:     sel_off = GEN_A;
    endcase
    pc = sel_base + sel_off;
  end

endmodule

// File: rtl/exc_xlat_regs.sv
module exc_xlat_regs #(
  parameter int AW     = 32,
  parameter int ASID_W = 8,
  parameter int VPN_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_addr,
  input  logic              upd_xlat,
  input  logic [AW-1:0]     vaddr,
  input  logic [ASID_W-1:0] asid,
  input  logic [VPN_W-1:0]  vpn,
  output logic [AW-1:0]     bad_vaddr,
  output logic [ASID_W-1:0] tr_asid,
  output logic [VPN_W-3:0]  tr_vpn2,
  output logic [1:0]        tr_vpn2x,
  output logic [VPN_W-3:0]  ctx_badvpn2
);

  localparam int VPN2_W = VPN_W - 2;

  logic [VPN2_W-1:0] vpn_pair;
  assign vpn_pair = vpn[VPN_W-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bad_vaddr   <= '0;
      tr_asid     <= '0;
      tr_vpn2     <= '0;
      tr_vpn2x    <= '0;
      ctx_badvpn2 <= '0;
    end else begin
      if (upd_addr) bad_vaddr <= vaddr;
      if (upd_xlat) begin
        tr_asid     <= asid;
        tr_vpn2     <= vpn_pair;
        tr_vpn2x    <= vpn[1:0];
        ctx_badvpn2 <= vpn_pair;
      end
    end
  end

  // R9: both copies of the page-pair number agree after a translation fault
  a_r9_pair_agree: assert property (@(posedge clk) disable iff (!rst_n)
    upd_xlat |=> (tr_vpn2 == ctx_badvpn2) && (tr_vpn2x == $past(vpn[1:0])));

  // R8: bad address holds when no address-class fault arrives
  a_r8_bad_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_addr |=> $stable(bad_vaddr));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          ASID_W   = 8,
  parameter int          VPN_W    = 21,
  parameter int          COP_W    = 2,
  parameter logic [31:0] BOOT_VEC = 32'hBFC0_0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_kind,
  input  logic              req_store,
  input  logic [AW-1:0]     req_pc,
  input  logic [AW-1:0]     req_vaddr,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [COP_W-1:0]  req_cop,
  input  logic              ctl_wr,
  input  logic              ctl_boot,
  input  logic              ctl_exl,
  input  logic              ctl_spread,
  input  logic [AW-1:0]     ctl_base,
  output logic              redirect_valid,
  output logic [AW-1:0]     redirect_pc,
  output logic              stat_boot,
  output logic              stat_exl,
  output logic              cause_spread,
  output logic [AW-1:0]     vec_base,
  output logic [CODE_W-1:0] cause_code,
  output logic [COP_W-1:0]  cause_ce,
  output logic [AW-1:0]     epc,
  output logic [AW-1:0]     bad_vaddr,
  output logic [ASID_W-1:0] tr_asid,
  output logic [VPN_W-3:0]  tr_vpn2,
  output logic [1:0]        tr_vpn2x,
  output logic [VPN_W-3:0]  ctx_badvpn2
);

  fault_kind_e   kind;
  fault_class_t  cls;
  logic [AW-1:0] vec_pc;
  logic          accept;

  assign kind      = fault_kind_e'(req_kind);
  assign req_ready = !redirect_valid && !ctl_wr;
  assign accept    = req_valid && req_ready;

  exc_code_map u_map (
    .kind  (kind),
    .store (req_store),
    .cls   (cls)
  );

  exc_vec_calc #(
    .AW       (AW),
    .BOOT_VEC (BOOT_VEC)
  ) u_vec (
    .kind   (kind),
    .boot   (stat_boot),
    .exl    (stat_exl),
    .spread (cause_spread),
    .base   (vec_base),
    .pc     (vec_pc)
  );

  exc_xlat_regs #(
    .AW     (AW),
    .ASID_W (ASID_W),
    .VPN_W  (VPN_W)
  ) u_xlat (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_addr    (accept && cls.is_addr),
    .upd_xlat    (accept && cls.is_xlat),
    .vaddr       (req_vaddr),
    .asid        (req_asid),
    .vpn         (req_vpn),
    .bad_vaddr   (bad_vaddr),
    .tr_asid     (tr_asid),
    .tr_vpn2     (tr_vpn2),
    .tr_vpn2x    (tr_vpn2x),
    .ctx_badvpn2 (ctx_badvpn2)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      stat_boot      <= 1'b1;
      stat_exl       <= 1'b0;
      cause_spread   <= 1'b0;
      vec_base       <= '0;
      cause_code     <= '0;
      cause_ce       <= '0;
      epc            <= '0;
    end else begin
      redirect_valid <= accept;
      if (ctl_wr) begin
        stat_boot    <= ctl_boot;
        stat_exl     <= ctl_exl;
        cause_spread <= ctl_spread;
        vec_base     <= ctl_base;
      end
      if (accept) begin
        redirect_pc <= vec_pc;
        cause_code  <= cls.code;
        if (cls.is_cop) cause_ce <= req_cop;
        if (!stat_exl) begin
          epc      <= req_pc;
          stat_exl <= 1'b1;
        end
      end
    end
  end

  // R2: redirect is a single-cycle pulse
  a_r2_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid);

  // R2: a taken request produces a redirect and holds off the next one
  a_r2_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (redirect_valid && !req_ready));

  // R11: the handler always runs with the in-handler bit set
  a_r11_exl_set: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> stat_exl);

  // R11: nested fault keeps the saved PC
  a_r11_epc_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && stat_exl) |=> $stable(epc));

  // R10: coprocessor field moves only on a coprocessor-unusable fault
  a_r10_ce_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_kind == 4'd10) |=> $stable(cause_ce));

  // R7: modified-page fault always reports code 1
  a_r7_mod_code: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == 4'd1) |=> cause_code == 5'd1);

endmodule

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;

  typedef struct packed {
    logic [3:0]  kind;
    logic [31:0] pc;
    logic [4:0]  code;
    logic [1:0]  ce;
    logic [31:0] epc;
    logic        exl;
    logic [31:0] bad;
    logic [7:0]  asid;
    logic [18:0] vpn2;
    logic [1:0]  vpn2x;
    logic [18:0] ctx;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_kind = '0;
  logic        req_store = 1'b0;
  logic [31:0] req_pc = '0, req_vaddr = '0;
  logic [7:0]  req_asid = '0;
  logic [20:0] req_vpn = '0;
  logic [1:0]  req_cop = '0;
  logic        ctl_wr = 1'b0, ctl_boot = 1'b0, ctl_exl = 1'b0, ctl_spread = 1'b0;
  logic [31:0] ctl_base = '0;
  logic        redirect_valid;
  logic [31:0] redirect_pc;
  logic        stat_boot, stat_exl, cause_spread;
  logic [31:0] vec_base;
  logic [4:0]  cause_code;
  logic [1:0]  cause_ce;
  logic [31:0] epc, bad_vaddr;
  logic [7:0]  tr_asid;
  logic [18:0] tr_vpn2, ctx_badvpn2;
  logic [1:0]  tr_vpn2x;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_store(req_store), .req_pc(req_pc),
    .req_vaddr(req_vaddr), .req_asid(req_asid), .req_vpn(req_vpn),
    .req_cop(req_cop), .ctl_wr(ctl_wr), .ctl_boot(ctl_boot), .ctl_exl(ctl_exl),
    .ctl_spread(ctl_spread), .ctl_base(ctl_base),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .stat_boot(stat_boot), .stat_exl(stat_exl), .cause_spread(cause_spread),
    .vec_base(vec_base), .cause_code(cause_code), .cause_ce(cause_ce),
    .epc(epc), .bad_vaddr(bad_vaddr), .tr_asid(tr_asid), .tr_vpn2(tr_vpn2),
    .tr_vpn2x(tr_vpn2x), .ctx_badvpn2(ctx_badvpn2)
  );

  int   n_chk = 0;
  int   n_err = 0;
  exp_t sb[$];

  // reference model state
  logic        m_boot = 1'b1, m_exl = 1'b0, m_spread = 1'b0;
  logic [31:0] m_base = '0, m_epc = '0, m_bad = '0;
  logic [1:0]  m_ce = '0;
  logic [7:0]  m_asid = '0;
  logic [18:0] m_vpn2 = '0, m_ctx = '0;
  logic [1:0]  m_vpn2x = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [4:0] ref_code(input logic [3:0] k, input logic st);
    case (k)
      4'd0: return 5'd0;   4'd1: return 5'd1;
      4'd2, 4'd3: return st ? 5'd3 : 5'd2;
      4'd4: return st ? 5'd5 : 5'd4;
      4'd5: return 5'd6;   4'd6: return 5'd7;   4'd7: return 5'd8;
      4'd8: return 5'd9;   4'd9: return 5'd10;  4'd10: return 5'd11;
      4'd11: return 5'd12; 4'd12: return 5'd13; 4'd13: return 5'd23;
      4'd14: return 5'd24; default: return 5'd25;
    endcase
  endfunction

  // push the expected result, then present the request until it is taken
  task automatic raise(input logic [3:0] k, input logic st, input logic [31:0] pc,
                       input logic [31:0] va, input logic [7:0] asid,
                       input logic [20:0] vpn, input logic [1:0] cop);
    exp_t e;
    logic [31:0] b, off;
    b   = m_boot ? 32'hBFC0_0200 : m_base;
    off = 32'h180;
    if (k == 4'd0 && m_spread) off = 32'h200;
    if (k == 4'd2 && !m_exl)   off = 32'h000;
    if (k == 4'd10) m_ce = cop;
    if (k >= 4'd1 && k <= 4'd4) m_bad = va;
    if (k >= 4'd1 && k <= 4'd3) begin
      m_asid = asid; m_vpn2 = vpn[20:2]; m_vpn2x = vpn[1:0]; m_ctx = vpn[20:2];
    end
    if (!m_exl) begin m_epc = pc; m_exl = 1'b1; end
    e.kind = k; e.pc = b + off; e.code = ref_code(k, st); e.ce = m_ce;
    e.epc = m_epc; e.exl = m_exl; e.bad = m_bad; e.asid = m_asid;
    e.vpn2 = m_vpn2; e.vpn2x = m_vpn2x; e.ctx = m_ctx;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_store = st; req_pc = pc;
    req_vaddr = va; req_asid = asid; req_vpn = vpn; req_cop = cop;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic set_ctl(input logic b, input logic e, input logic s,
                         input logic [31:0] base);
    @(negedge clk);
    req_valid = 1'b0;
    ctl_wr = 1'b1; ctl_boot = b; ctl_exl = e; ctl_spread = s; ctl_base = base;
    #1 chk(req_ready == 1'b0, "R2", "ready during control write", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    ctl_wr = 1'b0;
    m_boot = b; m_exl = e; m_spread = s; m_base = base;
    chk(stat_boot == b && stat_exl == e && cause_spread == s, "R12", "status bits",
        {29'b0, stat_boot, stat_exl, cause_spread}, {29'b0, b, e, s});
    chk(vec_base == base, "R12", "base register", vec_base, base);
  endtask

  // monitor: compare every redirect against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && redirect_valid) begin
      exp_t e;
      string ptag, ctag;
      if (sb.size() == 0) begin
        chk(1'b0, "R2", "unexpected redirect", redirect_pc, 32'd0);
      end else begin
        e = sb.pop_front();
        ptag = (e.kind == 4'd0) ? "R4" : (e.kind == 4'd2) ? "R5" : "R3";
        ctag = (e.kind >= 4'd1 && e.kind <= 4'd4) ? "R7" : "R6";
        chk(redirect_pc == e.pc, ptag, "redirect pc", redirect_pc, e.pc);
        chk(cause_code == e.code, ctag, "cause code", {27'b0, cause_code}, {27'b0, e.code});
        chk(cause_ce == e.ce, "R10", "coprocessor field", {30'b0, cause_ce}, {30'b0, e.ce});
        chk(epc == e.epc, "R11", "saved pc", epc, e.epc);
        chk(stat_exl == e.exl, "R11", "in-handler bit", {31'b0, stat_exl}, {31'b0, e.exl});
        chk(bad_vaddr == e.bad, "R8", "bad address", bad_vaddr, e.bad);
        chk(tr_asid == e.asid && tr_vpn2 == e.vpn2 && tr_vpn2x == e.vpn2x
            && ctx_badvpn2 == e.ctx, "R9", "translation fields",
            {tr_asid, tr_vpn2x, 3'b0, tr_vpn2}, {e.asid, e.vpn2x, 3'b0, e.vpn2});
        chk(req_ready == 1'b0, "R2", "ready during redirect", {31'b0, req_ready}, 32'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int cnt;
    cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(redirect_valid == 1'b0 && req_ready == 1'b1, "R1", "handshake reset",
        {30'b0, redirect_valid, req_ready}, 32'd1);
    chk(stat_boot == 1'b1 && stat_exl == 1'b0 && cause_spread == 1'b0, "R1", "status reset",
        {29'b0, stat_boot, stat_exl, cause_spread}, 32'd4);
    chk(vec_base == 0 && epc == 0 && bad_vaddr == 0 && cause_code == 0 && cause_ce == 0,
        "R1", "registers reset", epc | bad_vaddr | vec_base, 32'd0);
    chk(tr_asid == 0 && tr_vpn2 == 0 && tr_vpn2x == 0 && ctx_badvpn2 == 0, "R1",
        "translation reset", {tr_asid, tr_vpn2x, 3'b0, tr_vpn2}, 32'd0);
    rst_n = 1'b1;

    // sweep every kind over every boot / in-handler / spread setting
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 2; s++)
        for (int e = 0; e < 2; e++)
          for (int k = 0; k < 16; k++) begin
            logic [31:0] va;
            set_ctl(b[0], e[0], s[0], 32'h8000_1000 + (b << 16) + (s << 12));
            va = 32'h1234_5678 ^ (k << 13) ^ (b << 28) ^ (s << 4) ^ (e << 7);
            raise(k[3:0], k[0] ^ e[0] ^ s[0], 32'h0040_0000 + cnt * 4, va,
                  {k[3:0], b[0], s[0], e[0], 1'b1}, va[31:11], k[1:0] ^ {s[0], e[0]});
            cnt++;
          end

    // back-to-back requests: second and third are held off, nested entry
    set_ctl(1'b0, 1'b0, 1'b1, 32'h9000_0000);
    raise(4'd2, 1'b1, 32'h0050_0000, 32'hCAFE_B000, 8'h5A, 21'h1ABCD, 2'd0);
    raise(4'd2, 1'b0, 32'h0050_0004, 32'hBEEF_1000, 8'hA5, 21'h0F0F3, 2'd0);
    raise(4'd10, 1'b0, 32'h0050_0008, 32'h0, 8'h0, 21'h0, 2'd3);
    raise(4'd0, 1'b0, 32'h0050_000C, 32'h0, 8'h0, 21'h0, 2'd0);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R2", "all requests redirected", sb.size(), 32'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule